// File: doc/BRIEF.md
# Serial Configuration Port with Register Decode

This block is the control port of a radio front end's digital section. A host shifts a 24-bit word in over three wires: a serial clock, a serial data line and a load strobe. The word is assembled most significant bit first. When the load strobe rises, the whole word is committed into exactly one of five configuration registers. The destination is picked by a small field at the bottom of the word. The three serial inputs are synchronized into the block's own clock before any decision is made, so the host may run its serial clock at any rate slower than the block clock.

Besides the raw contents of every configuration register, the block derives output-stage controls from the control register. It provides a one-hot current level for the LO output stage, a high/low power select for the transmit output stage, and two output-stage enables. Each enable can be held off until an external digital lock-detect signal is asserted, and each is registered so that it reacts one clock after lock changes.

Top module: `serial_cfg_port`

## Requirements
- R1: Each synchronized rising edge of the serial clock captures one data bit, most significant bit first. After 24 edges the first bit sent is in bit 23 of the committed word and the last bit sent is in bit 0.
- R2: Serial-clock activity without a load-strobe rising edge leaves every configuration register unchanged.
- R3: On a commit, word bits [1:0] pick the destination, and bit 2 qualifies select 01. Select 00 writes the control register. Select 01 writes the transmit register when bit 2 is 0 and the receive-calibration register when bit 2 is 1. Select 10 writes the LO register. Select 11 writes the receive-filter register. Exactly one register is written per commit, and it takes the full 24-bit word.
- R4: A commit happens once per synchronized rising edge of the load strobe. Holding the strobe high, even while further bits are shifted in, causes no second commit.
- R5: While reset is asserted, all five configuration registers read zero.
- R6: Control-register bits [5:4] are the LO power code. `lo_level` is one-hot, with bit n set for code n (00 lowest current through 11 highest).
- R7: When control-register bit 6 (LO mute-until-lock) is 1 and lock detect is 0, `lo_out_en` is 0. In every other case it is 1 one clock later.
- R8: When control-register bit 7 (transmit mute-until-lock) is 1 and lock detect is 0, `tx_out_en` is 0. In every other case it is 1 one clock later. This flag is independent of bit 6.
- R9: `tx_pwr_hi` follows control-register bit 8 (1 selects the higher transmit output power).
- R10: If lock detect falls while a mute flag is set, the matching enable is 0 after the very next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from host, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe; a rising edge commits the word |
| lock_det | input | 1 | Digital lock detect, synchronous to clk |
| ctrl_word | output | 24 | Control register |
| tx_word | output | 24 | Transmit register |
| rxcal_word | output | 24 | Receive-calibration register |
| lo_word | output | 24 | LO register |
| rxflt_word | output | 24 | Receive-filter register |
| lo_level | output | 4 | One-hot LO output-stage current level |
| tx_pwr_hi | output | 1 | Transmit output high-power select |
| lo_out_en | output | 1 | LO output-stage enable after lock gating |
| tx_out_en | output | 1 | Transmit output-stage enable after lock gating |

## Verification
Five words are sent, one for each decode value including both settings of bit 2. Their bit patterns differ from each other, and a set top bit shows whether the order or the destination has gone wrong. A full word is shifted with no strobe to separate shifting from committing. A second word is then shifted in while the strobe is held high, which tells a single edge-triggered commit from a level-triggered one. Each power code is stepped through. Lock detect is toggled with each mute flag set alone and both set together, which checks that the two gates are independent and that the enable drops after exactly one clock.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam int CFG_WORD_W   = 24;
  localparam int CFG_NUM_DEST = 5;

  // Control-register field positions
  localparam int LO_PWR_LSB  = 4;
  localparam int LO_MUTE_BIT = 6;
  localparam int TX_MUTE_BIT = 7;
  localparam int TX_PWR_BIT  = 8;

  typedef enum logic [2:0] {
    DST_CTRL  = 3'd0,
    DST_TX    = 3'd1,
    DST_RXCAL = 3'd2,
    DST_LO    = 3'd3,
    DST_RXFLT = 3'd4
  } dest_e;

  // Destination from the low three bits of a word
  function automatic dest_e dest_of(input logic [2:0] cbits);
    case (cbits[1:0])
      2'b00:   return DST_CTRL;
      2'b01:   return cbits[2] ? DST_RXCAL : DST_TX;
      2'b10:   return DST_LO;
      default: return DST_RXFLT;
    endcase
  endfunction

  function automatic logic [3:0] level_onehot(input logic [1:0] code);
    return 4'b0001 << code;
  endfunction

  // Enable is withheld only when muting is requested and lock is absent
  function automatic logic lock_gate(input logic mute, input logic locked);
    return !(mute && !locked);
  endfunction

endpackage

// File: rtl/cfg_shift_in.sv
module cfg_shift_in #(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  output logic [WORD_W-1:0] shift_word,
  output logic              bit_strobe,
  output logic              commit_pulse
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_sy, sdat_sy, load_sy;
  logic                   sclk_last, load_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy   <= '0;
      sdat_sy   <= '0;
      load_sy   <= '0;
      sclk_last <= 1'b0;
      load_last <= 1'b0;
    end else begin
      sclk_sy   <= {sclk_sy[TOP-1:0], ser_clk};
      sdat_sy   <= {sdat_sy[TOP-1:0], ser_data};
      load_sy   <= {load_sy[TOP-1:0], ser_load};
      sclk_last <= sclk_sy[TOP];
      load_last <= load_sy[TOP];
    end
  end

  assign bit_strobe   = sclk_sy[TOP] & ~sclk_last;
  assign commit_pulse = load_sy[TOP] & ~load_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          shift_word <= '0;
    else if (bit_strobe) shift_word <= {shift_word[WORD_W-2:0], sdat_sy[TOP]};
  end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfgp_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int NUM_DEST = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           commit,
  input  logic [WORD_W-1:0]              word,
  output logic [NUM_DEST-1:0]            wr_onehot,
  output logic [NUM_DEST-1:0][WORD_W-1:0] regs
);

  dest_e sel;
  assign sel = dest_of(word[2:0]);

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_reg
    logic [WORD_W-1:0] q;
    assign wr_onehot[g] = commit && (int'(sel) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            q <= '0;
      else if (wr_onehot[g]) q <= word;
    end
    assign regs[g] = q;
  end

endmodule

// File: rtl/cfg_out_gate.sv
module cfg_out_gate
  import cfgp_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] ctrl,
  input  logic              lock_det,
  output logic [3:0]        lo_level,
  output logic              tx_pwr_hi,
  output logic              lo_out_en,
  output logic              tx_out_en
);

  assign lo_level  = level_onehot(ctrl[LO_PWR_LSB +: 2]);
  assign tx_pwr_hi = ctrl[TX_PWR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_out_en <= 1'b0;
      tx_out_en <= 1'b0;
    end else begin
      lo_out_en <= lock_gate(ctrl[LO_MUTE_BIT], lock_det);
      tx_out_en <= lock_gate(ctrl[TX_MUTE_BIT], lock_det);
    end
  end

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import cfgp_pkg::*;
#(
  parameter int WORD_W      = CFG_WORD_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  input  logic              lock_det,
  output logic [WORD_W-1:0] ctrl_word,
  output logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rxcal_word,
  output logic [WORD_W-1:0] lo_word,
  output logic [WORD_W-1:0] rxflt_word,
  output logic [3:0]        lo_level,
  output logic              tx_pwr_hi,
  output logic              lo_out_en,
  output logic              tx_out_en
);

  localparam int NUM_DEST = CFG_NUM_DEST;

  logic [WORD_W-1:0]                shift_word;
  logic                             bit_strobe;
  logic                             commit_pulse;
  logic [NUM_DEST-1:0]              wr_onehot;
  logic [NUM_DEST-1:0][WORD_W-1:0]  regs;

  cfg_shift_in #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_clk      (ser_clk),
    .ser_data     (ser_data),
    .ser_load     (ser_load),
    .shift_word   (shift_word),
    .bit_strobe   (bit_strobe),
    .commit_pulse (commit_pulse)
  );

  cfg_reg_bank #(.WORD_W(WORD_W), .NUM_DEST(NUM_DEST)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit_pulse),
    .word      (shift_word),
    .wr_onehot (wr_onehot),
    .regs      (regs)
  );

  assign ctrl_word  = regs[int'(DST_CTRL)];
  assign tx_word    = regs[int'(DST_TX)];
  assign rxcal_word = regs[int'(DST_RXCAL)];
  assign lo_word    = regs[int'(DST_LO)];
  assign rxflt_word = regs[int'(DST_RXFLT)];

  cfg_out_gate #(.WORD_W(WORD_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl_word),
    .lock_det  (lock_det),
    .lo_level  (lo_level),
    .tx_pwr_hi (tx_pwr_hi),
    .lo_out_en (lo_out_en),
    .tx_out_en (tx_out_en)
  );

endmodule

// File: rtl/cfg_port_checks.sv
module cfg_port_checks
  import cfgp_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int NUM_DEST = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                commit_pulse,
  input logic [NUM_DEST-1:0] wr_onehot,
  input logic [WORD_W-1:0]   shift_word,
  input logic [WORD_W-1:0]   ctrl_word,
  input logic [WORD_W-1:0]   tx_word,
  input logic [WORD_W-1:0]   rxcal_word,
  input logic [WORD_W-1:0]   lo_word,
  input logic [WORD_W-1:0]   rxflt_word,
  input logic                lock_det,
  input logic [3:0]          lo_level,
  input logic                lo_out_en,
  input logic                tx_out_en
);

  // R3: a commit writes exactly one destination
  a_r3_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> $countones(wr_onehot) == 1);

  // R3: select 00 lands the whole word in the control register
  a_r3_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && shift_word[1:0] == 2'b00) |=> ctrl_word == $past(shift_word));

  // R2: with no commit, no register moves
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_pulse |=> ($stable(ctrl_word) && $stable(tx_word) && $stable(rxcal_word)
                       && $stable(lo_word) && $stable(rxflt_word)));

  // R4: commits never occur on consecutive cycles
  a_r4_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !commit_pulse);

  // R6: current level is always one-hot
  a_r6_level_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lo_level) == 1);

  // R7: LO muted without lock
  a_r7_lo_muted: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[LO_MUTE_BIT] && !lock_det) |=> !lo_out_en);

  // R7: LO enabled otherwise
  a_r7_lo_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_word[LO_MUTE_BIT] || lock_det) |=> lo_out_en);

  // R8: transmit gating
  a_r8_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[TX_MUTE_BIT] && !lock_det) |=> !tx_out_en);

  // R10: loss of lock drops a muted enable on the next edge
  a_r10_lock_loss: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lock_det) && ctrl_word[TX_MUTE_BIT]) |=> !tx_out_en);

endmodule

bind serial_cfg_port cfg_port_checks #(.WORD_W(WORD_W), .NUM_DEST(NUM_DEST)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .commit_pulse (commit_pulse),
  .wr_onehot    (wr_onehot),
  .shift_word   (shift_word),
  .ctrl_word    (ctrl_word),
  .tx_word      (tx_word),
  .rxcal_word   (rxcal_word),
  .lo_word      (lo_word),
  .rxflt_word   (rxflt_word),
  .lock_det     (lock_det),
  .lo_level     (lo_level),
  .lo_out_en    (lo_out_en),
  .tx_out_en    (tx_out_en)
);

// File: tb/serial_cfg_port_bench.sv
module serial_cfg_port_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, lock_det = 1'b0;
  logic [23:0] ctrl_word, tx_word, rxcal_word, lo_word, rxflt_word;
  logic [3:0]  lo_level;
  logic        tx_pwr_hi, lo_out_en, tx_out_en;

  always #2 clk = ~clk;

  serial_cfg_port u_serial_cfg_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .lock_det(lock_det),
    .ctrl_word(ctrl_word), .tx_word(tx_word), .rxcal_word(rxcal_word),
    .lo_word(lo_word), .rxflt_word(rxflt_word), .lo_level(lo_level),
    .tx_pwr_hi(tx_pwr_hi), .lo_out_en(lo_out_en), .tx_out_en(tx_out_en)
  );

  int checks = 0;
  int fails  = 0;
  bit quiet  = 1'b0;
  bit done   = 1'b0;

  // Reference model: index 0 ctrl, 1 tx, 2 rxcal, 3 lo, 4 rxflt
  logic [23:0] model [5];
  logic        lock_seen = 1'b0;

  always @(posedge clk) lock_seen <= lock_det;

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int where_to(input logic [23:0] w);
    if (w[1] == 1'b1) return w[0] ? 4 : 3;
    if (w[0] == 1'b0) return 0;
    return w[2] ? 2 : 1;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk) ser_data = b;
    repeat (2) @(negedge clk);
    ser_clk = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic shift_in(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic load_pulse(input int hold);
    @(negedge clk) begin quiet = 1'b0; ser_load = 1'b1; end
    repeat (hold) @(negedge clk);
    ser_load = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic commit_model(input logic [23:0] w);
    model[where_to(w)] = w;
    quiet = 1'b1;
  endtask

  task automatic check_all(input string req);
    chk({req, " ctrl"},  ctrl_word,  model[0]);
    chk({req, " tx"},    tx_word,    model[1]);
    chk({req, " rxcal"}, rxcal_word, model[2]);
    chk({req, " lo"},    lo_word,    model[3]);
    chk({req, " rxflt"}, rxflt_word, model[4]);
  endtask

  task automatic write_word(input logic [23:0] w, input string req);
    shift_in(w);
    load_pulse(3);
    commit_model(w);
    check_all(req);
  endtask

  // Every-clock comparison while no commit is in flight (R2 R6 R7 R8 R9)
  always @(negedge clk) begin
    if (quiet && !done) begin
      chk("R2 hold ctrl", ctrl_word, model[0]);
      chk("R2 hold lo", lo_word, model[3]);
      chk("R6 level", {20'd0, lo_level}, 24'(1) << model[0][5:4]);
      chk("R9 txpwr", {23'd0, tx_pwr_hi}, {23'd0, model[0][8]});
      chk("R7 lo_en", {23'd0, lo_out_en}, {23'd0, !(model[0][6] && !lock_seen)});
      chk("R8 tx_en", {23'd0, tx_out_en}, {23'd0, !(model[0][7] && !lock_seen)});
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    check_all("R5 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    quiet = 1'b1;

    // R1 and R3: one word per destination
    write_word(24'h800010, "R1 R3 ctrl");
    chk("R1 top bit", {23'd0, ctrl_word[23]}, 24'd1);
    write_word(24'h0F0F01, "R3 tx");
    write_word(24'hF0F005, "R3 rxcal");
    write_word(24'h333332, "R3 lo");

    // R2: shift with no strobe
    shift_in(24'h123457);
    check_all("R2 shift only");
    load_pulse(2);
    commit_model(24'h123457);
    check_all("R3 rxflt");

    // R4: strobe held high while a second word is shifted
    shift_in(24'h55AA02);
    @(negedge clk) begin quiet = 1'b0; ser_load = 1'b1; end
    shift_in(24'h777776);
    repeat (10) @(negedge clk);
    model[3] = 24'h55AA02;
    check_all("R4 held strobe");
    ser_load = 1'b0;
    repeat (6) @(negedge clk);
    check_all("R4 after release");
    load_pulse(5);
    commit_model(24'h777776);
    check_all("R4 next edge");

    // R6: all power codes
    for (int c = 0; c < 4; c++) begin
      write_word(24'(c) << 4, "R6 code");
      chk("R6 onehot", {20'd0, lo_level}, 24'(1) << c);
    end

    // R7 R8 R9 R10: both mute flags, high transmit power
    lock_det = 1'b0;
    write_word(24'h0001C0, "R9 ctrl");
    chk("R7 muted", {23'd0, lo_out_en}, 24'd0);
    chk("R8 muted", {23'd0, tx_out_en}, 24'd0);
    @(negedge clk) lock_det = 1'b1;
    @(negedge clk);
    chk("R7 locked", {23'd0, lo_out_en}, 24'd1);
    chk("R8 locked", {23'd0, tx_out_en}, 24'd1);
    lock_det = 1'b0;
    @(negedge clk);
    chk("R10 lo drop", {23'd0, lo_out_en}, 24'd0);
    chk("R10 tx drop", {23'd0, tx_out_en}, 24'd0);

    // R8: transmit flag alone
    write_word(24'h000080, "R8 ctrl");
    repeat (2) @(negedge clk);
    chk("R8 tx only muted", {23'd0, tx_out_en}, 24'd0);
    chk("R7 lo free", {23'd0, lo_out_en}, 24'd1);

    // R7: LO flag alone, lock toggling
    write_word(24'h000040, "R7 ctrl");
    chk("R7 lo only muted", {23'd0, lo_out_en}, 24'd0);
    chk("R8 tx free", {23'd0, tx_out_en}, 24'd1);
    @(negedge clk) lock_det = 1'b1;
    repeat (3) @(negedge clk);
    lock_det = 1'b0;
    @(negedge clk);
    chk("R10 lo drop alone", {23'd0, lo_out_en}, 24'd0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule